// File: doc/BRIEF.md
# Interprocessor Interrupt Command Register

This block holds the two command words that a core's software uses to send an interrupt message to another core, to itself, or to every core. Software first stores a destination ID in the high word, then writes the low word with the vector, delivery mode, level flag and a two-bit destination shorthand. Only the write to the low word launches the message. The block works out the real target from the shorthand, the stored ID and the local core ID, and then presents one message on a valid/ready output toward the interconnect.

A delivery-pending flag in the low word reads as set from the launching write until the interconnect accepts the message. While a message waits, the block rejects any further write to the low word and raises a sticky error bit. A write to the high word is still accepted during that time and only affects later sends.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset `msgValid` and `sendErr` are 0, and a read of the low word (byte offset 0x300) or of the high word (byte offset 0x310) returns 0.
- R2: A write to the low word at offset 0x300 while no message is pending raises `msgValid` from the next cycle on. The message carries the vector from bits 7:0, the delivery mode from bits 10:8 and the level flag from bit 14 of the written data.
- R3: A write to the high word at offset 0x310 stores bits 31:24 as the destination ID and does not launch a message. A read of the high word returns that ID in bits 31:24 and 0 in all other bits.
- R4: The shorthand in bits 19:18 of the low word sets `msgDestKind` and `msgDestId`. Value 0 gives kind 0 with the stored ID, or kind 2 with ID 0xFF when the stored ID is 0xFF. Value 1 gives kind 1 with the local core ID. Value 2 gives kind 2 with ID 0xFF. Value 3 gives kind 3 with the local core ID, which names the core to exclude.
- R5: While `msgValid` is 1 and `msgReady` is 0, every message field holds steady. In the cycle after `msgValid` and `msgReady` are both 1, `msgValid` is 0.
- R6: A read of the low word returns the stored vector (bits 7:0), mode (bits 10:8), level (bit 14) and shorthand (bits 19:18), plus the live pending flag in bit 12. All other bits read as 0.
- R7: A write to the low word while a message is pending is ignored, which leaves the outgoing message and the stored fields unchanged. It sets `sendErr`, and `sendErr` stays 1 until reset.
- R8: A write to the high word while a message is pending updates the stored ID but leaves the in-flight message unchanged.
- R9: A write to any other offset has no effect, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; data appears the next cycle |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Registered read data |
| localId | input | 8 | ID of this core |
| msgValid | output | 1 | Outgoing message valid |
| msgReady | input | 1 | Interconnect accepts the message |
| msgVector | output | 8 | Interrupt vector |
| msgMode | output | 3 | Delivery mode |
| msgLevel | output | 1 | Level-assert flag |
| msgDestKind | output | 2 | 0 ID, 1 self, 2 all, 3 all except self |
| msgDestId | output | 8 | Resolved destination or excluded core ID |
| sendErr | output | 1 | Sticky flag: low word was written while a message was pending |

## Verification
A write to the low word can land in the same cycle in which the interconnect accepts the pending message. The block decides by the pending flag as it stood before that edge, so the write must be rejected. The bench provokes this collision by asserting the write and `msgReady` in the same cycle. It then expects the error bit set, `msgValid` low afterwards, and the old vector still in the low-word readback. In a second overlap, the high word is rewritten while a message is held; the outgoing ID must stay unchanged and the new ID must read back.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DATA_W = 32;
  localparam int VEC_W  = 8;
  localparam int MODE_W = 3;
  localparam int ID_W   = 8;
  localparam int SH_W   = 2;

  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int PEND_BIT  = 12;
  localparam int LEVEL_BIT = 14;
  localparam int SH_LSB    = 18;
  localparam int ID_LSB    = 24;

  localparam logic [ID_W-1:0] BCAST_ID = '1;

  typedef enum logic [1:0] {
    DK_ID     = 2'd0,
    DK_SELF   = 2'd1,
    DK_ALL    = 2'd2,
    DK_OTHERS = 2'd3
  } destKind_e;

  typedef struct packed {
    logic loadDest;
    logic loadCmd;
    logic rdLow;
    logic rdHigh;
    logic rdAny;
  } ctrlStrb_t;
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LOW_OFS  = 12'h300,
  parameter logic [ADDR_W-1:0] HIGH_OFS = 12'h310
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              msgReady,
  output ctrlStrb_t         strb,
  output logic              pending,
  output logic              sendErr
);
  logic hitLow, hitHigh, lowWrite, accept;

  assign hitLow   = (regAddr == LOW_OFS);
  assign hitHigh  = (regAddr == HIGH_OFS);
  assign lowWrite = regWrEn && hitLow;
  assign accept   = pending && msgReady;

  always_comb begin
    strb          = '0;
    strb.loadDest = regWrEn && hitHigh;
    strb.loadCmd  = lowWrite && !pending;
    strb.rdLow    = regRdEn && hitLow;
    strb.rdHigh   = regRdEn && hitHigh;
    strb.rdAny    = regRdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      sendErr <= 1'b0;
    end else begin
      if (strb.loadCmd)  pending <= 1'b1;
      else if (accept)   pending <= 1'b0;
      if (lowWrite && pending) sendErr <= 1'b1;
    end
  end
endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              pending,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ID_W-1:0]   localId,
  output logic [DATA_W-1:0] regRdData,
  output logic [VEC_W-1:0]  msgVector,
  output logic [MODE_W-1:0] msgMode,
  output logic              msgLevel,
  output logic [1:0]        msgDestKind,
  output logic [ID_W-1:0]   msgDestId
);
  logic [ID_W-1:0]   destReg;
  logic [VEC_W-1:0]  vecReg;
  logic [MODE_W-1:0] modeReg;
  logic              levelReg;
  logic [SH_W-1:0]   shReg;

  logic [VEC_W-1:0]  wVec;
  logic [MODE_W-1:0] wMode;
  logic              wLevel;
  logic [SH_W-1:0]   wSh;
  destKind_e         resKind;
  logic [ID_W-1:0]   resId;
  logic [DATA_W-1:0] lowImage, highImage;
  logic              unusedBits;

  assign wVec   = regWrData[VEC_LSB +: VEC_W];
  assign wMode  = regWrData[MODE_LSB +: MODE_W];
  assign wLevel = regWrData[LEVEL_BIT];
  assign wSh    = regWrData[SH_LSB +: SH_W];
  assign unusedBits = ^{regWrData[23:20], regWrData[17:15], regWrData[13:11]};

  // Destination resolution from shorthand, stored ID and local ID
  always_comb begin
    unique case (wSh)
      2'd1: begin resKind = DK_SELF;   resId = localId;  end
      2'd2: begin resKind = DK_ALL;    resId = BCAST_ID; end
      2'd3: begin resKind = DK_OTHERS; resId = localId;  end
      default: begin
        if (destReg == BCAST_ID) begin
          resKind = DK_ALL;
          resId   = BCAST_ID;
        end else begin
          resKind = DK_ID;
          resId   = destReg;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destReg     <= '0;
      vecReg      <= '0;
      modeReg     <= '0;
      levelReg    <= 1'b0;
      shReg       <= '0;
      msgVector   <= '0;
      msgMode     <= '0;
      msgLevel    <= 1'b0;
      msgDestKind <= DK_ID;
      msgDestId   <= '0;
    end else begin
      if (strb.loadDest) destReg <= regWrData[ID_LSB +: ID_W];
      if (strb.loadCmd) begin
        vecReg      <= wVec;
        modeReg     <= wMode;
        levelReg    <= wLevel;
        shReg       <= wSh;
        msgVector   <= wVec;
        msgMode     <= wMode;
        msgLevel    <= wLevel;
        msgDestKind <= resKind;
        msgDestId   <= resId;
      end
    end
  end

  always_comb begin
    lowImage = '0;
    lowImage[VEC_LSB +: VEC_W]   = vecReg;
    lowImage[MODE_LSB +: MODE_W] = modeReg;
    lowImage[PEND_BIT]           = pending;
    lowImage[LEVEL_BIT]          = levelReg;
    lowImage[SH_LSB +: SH_W]     = shReg;
    highImage = '0;
    highImage[ID_LSB +: ID_W]    = destReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (strb.rdAny) begin
      if (strb.rdLow)       regRdData <= lowImage;
      else if (strb.rdHigh) regRdData <= highImage;
      else                  regRdData <= '0;
    end
  end
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LOW_OFS  = 12'h300,
  parameter logic [ADDR_W-1:0] HIGH_OFS = 12'h310
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [7:0]        localId,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [7:0]        msgVector,
  output logic [2:0]        msgMode,
  output logic              msgLevel,
  output logic [1:0]        msgDestKind,
  output logic [7:0]        msgDestId,
  output logic              sendErr
);
  ctrlStrb_t strb;
  logic      pending;

  ipi_ctrl #(.ADDR_W(ADDR_W), .LOW_OFS(LOW_OFS), .HIGH_OFS(HIGH_OFS)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .msgReady(msgReady), .strb(strb),
    .pending(pending), .sendErr(sendErr)
  );

  ipi_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .pending(pending),
    .regWrData(regWrData), .localId(localId), .regRdData(regRdData),
    .msgVector(msgVector), .msgMode(msgMode), .msgLevel(msgLevel),
    .msgDestKind(msgDestKind), .msgDestId(msgDestId)
  );

  assign msgValid = pending;
endmodule

// File: rtl/ipi_cmd_reg_chk.sv
module ipi_cmd_reg_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LOW_OFS  = 12'h300,
  parameter logic [ADDR_W-1:0] HIGH_OFS = 12'h310
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              msgValid,
  input logic              msgReady,
  input logic [7:0]        msgVector,
  input logic [2:0]        msgMode,
  input logic              msgLevel,
  input logic [1:0]        msgDestKind,
  input logic [7:0]        msgDestId,
  input logic              sendErr
);
  // R2
  launch_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == LOW_OFS && !msgValid) |=> msgValid);

  // R3
  high_no_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == HIGH_OFS && !msgValid) |=> !msgValid);

  // R5
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgVector) && $stable(msgMode)
      && $stable(msgLevel) && $stable(msgDestKind) && $stable(msgDestId)));

  // R5
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady) |=> !msgValid);

  // R7
  reject_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == LOW_OFS && msgValid) |=> sendErr);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendErr |=> sendErr);
endmodule

bind ipi_cmd_reg ipi_cmd_reg_chk #(.ADDR_W(ADDR_W), .LOW_OFS(LOW_OFS), .HIGH_OFS(HIGH_OFS)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .msgValid(msgValid), .msgReady(msgReady), .msgVector(msgVector),
  .msgMode(msgMode), .msgLevel(msgLevel), .msgDestKind(msgDestKind),
  .msgDestId(msgDestId), .sendErr(sendErr)
);

// File: tb/sim_ipi_cmd_reg.sv
module sim_ipi_cmd_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] LOW  = 12'h300;
  localparam logic [11:0] HIGH = 12'h310;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0]  localId = 8'h3C;
  logic        msgValid, msgReady = 1'b0;
  logic [7:0]  msgVector, msgDestId;
  logic [2:0]  msgMode;
  logic        msgLevel, sendErr;
  logic [1:0]  msgDestKind;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_cmd_reg u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .localId(localId), .msgValid(msgValid), .msgReady(msgReady),
    .msgVector(msgVector), .msgMode(msgMode), .msgLevel(msgLevel),
    .msgDestKind(msgDestKind), .msgDestId(msgDestId), .sendErr(sendErr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit rdy);
    regWrEn = 1'b1; regAddr = a; regWrData = d; msgReady = rdy;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; msgReady = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic accept();
    msgReady = 1'b1;
    @(posedge clk); @(negedge clk);
    msgReady = 1'b0;
  endtask

  function automatic logic [31:0] lowWord(int sh, int lvl, int pend, int mode, int vec);
    return (32'(sh) << 18) | (32'(lvl) << 14) | (32'(pend) << 12) | (32'(mode) << 8) | 32'(vec);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] dests [5] = '{8'h00, 8'h05, 8'h7F, 8'hFE, 8'hFF};
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    chk(msgValid == 0, "R1 valid", 32'(msgValid), 0);
    chk(sendErr == 0, "R1 err", 32'(sendErr), 0);
    rd(LOW, d);  chk(d == 0, "R1 low", d, 0);
    rd(HIGH, d); chk(d == 0, "R1 high", d, 0);

    // Sweep shorthand x destination x mode
    for (int sh = 0; sh < 4; sh++) begin
      for (int di = 0; di < 5; di++) begin
        for (int m = 0; m < 8; m++) begin
          int vec = (sh * 61 + di * 23 + m * 7 + 17) % 256;
          int lvl = (m + di) % 2;
          logic [1:0] eKind;
          logic [7:0] eId;
          localId = dests[di] ^ 8'h3C;
          wr(HIGH, {dests[di], 24'h0}, 0);
          chk(msgValid == 0, "R3 no launch", 32'(msgValid), 0);
          rd(HIGH, d);
          chk(d == {dests[di], 24'h0}, "R3 readback", d, {dests[di], 24'h0});
          wr(LOW, lowWord(sh, lvl, 0, m, vec) | 32'h00F3A800, 0);
          case (sh)
            1: begin eKind = 2'd1; eId = localId; end
            2: begin eKind = 2'd2; eId = 8'hFF; end
            3: begin eKind = 2'd3; eId = localId; end
            default: begin
              eKind = (dests[di] == 8'hFF) ? 2'd2 : 2'd0;
              eId = dests[di];
            end
          endcase
          chk(msgValid == 1, "R2 launch", 32'(msgValid), 1);
          chk(msgVector == 8'(vec) && msgMode == 3'(m) && msgLevel == 1'(lvl), "R2 fields",
              {15'h0, msgLevel, 5'h0, msgMode, msgVector}, {15'h0, 1'(lvl), 5'h0, 3'(m), 8'(vec)});
          chk(msgDestKind == eKind && msgDestId == eId, "R4 resolve",
              {22'h0, msgDestKind, msgDestId}, {22'h0, eKind, eId});
          rd(LOW, d);
          chk(d == lowWord(sh, lvl, 1, m, vec), "R6 low pending", d, lowWord(sh, lvl, 1, m, vec));
          chk(msgValid == 1 && msgVector == 8'(vec), "R5 hold", 32'(msgVector), 32'(vec));
          accept();
          chk(msgValid == 0, "R5 clear", 32'(msgValid), 0);
          rd(LOW, d);
          chk(d == lowWord(sh, lvl, 0, m, vec), "R6 low idle", d, lowWord(sh, lvl, 0, m, vec));
        end
      end
    end
    chk(sendErr == 0, "R7 no err yet", 32'(sendErr), 0);

    // R9 other offsets
    wr(12'h304, 32'hFFFFFFFF, 0);
    wr(12'h320, 32'hFFFFFFFF, 0);
    chk(msgValid == 0, "R9 no launch", 32'(msgValid), 0);
    rd(12'h320, d); chk(d == 0, "R9 read zero", d, 0);
    rd(HIGH, d); chk(d == 32'hFF000000, "R9 high unchanged", d, 32'hFF000000);

    // R8 high write while pending
    localId = 8'h21;
    wr(HIGH, 32'h12000000, 0);
    wr(LOW, lowWord(0, 1, 0, 2, 8'h40), 0);
    wr(HIGH, 32'h34000000, 0);
    chk(msgDestId == 8'h12 && msgDestKind == 0, "R8 inflight id", 32'(msgDestId), 32'h12);
    rd(HIGH, d); chk(d == 32'h34000000, "R8 new id", d, 32'h34000000);

    // R7 collision: low write in the accept cycle
    wr(LOW, lowWord(2, 1, 0, 5, 8'h99), 1);
    chk(sendErr == 1, "R7 err set", 32'(sendErr), 1);
    chk(msgValid == 0, "R7 no relaunch", 32'(msgValid), 0);
    rd(LOW, d);
    chk(d == lowWord(0, 1, 0, 2, 8'h40), "R7 fields kept", d, lowWord(0, 1, 0, 2, 8'h40));
    wr(LOW, lowWord(1, 1, 0, 0, 8'h55), 0);
    chk(msgValid == 1 && msgDestKind == 2'd1 && msgDestId == 8'h21, "R4 self after err",
        {22'h0, msgDestKind, msgDestId}, {22'h0, 2'd1, 8'h21});
    wr(LOW, lowWord(3, 0, 0, 7, 8'hAA), 0);
    chk(msgVector == 8'h55, "R7 ignored while pending", 32'(msgVector), 32'h55);
    accept();
    chk(sendErr == 1, "R7 sticky", 32'(sendErr), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule